// File: doc/BRIEF.md
# MII management command engine

This block executes PHY management commands that software issues as single 32-bit frame words through a small register port. It holds its own model of one PHY's 32 x 16-bit register file. A frame with a valid start code that names the local PHY reads or writes that file. Any other frame completes without touching it. Completion is shown by setting the low turnaround bit of the stored frame word. A read command also returns the register contents in the low 16 bits of that word.

The engine applies the self-clearing side effects of the PHY control register: soft reset, and restart of negotiation. It keeps the link bits of the status and link-partner registers in line with a `link_up` input. A link change raises a sticky event, which drives `irq` and clears when it is read. A configuration register carries two read-only transceiver-detect bits.

Register port offsets (`reg_addr`): 0 is configuration, 1 is the frame word, 2 is the link event (bit 0), and 3 reads as zero. Writes take effect at the clock edge. Read data is combinational from the current state.

Top module: `mii_mgmt_engine`

## Requirements
- R1: A frame write whose start field (bits 31:30) is not 01, or whose PHY address (bits 27:23) is not 1, changes no PHY register. The stored frame equals the written word with bit 16 set.
- R2: A valid frame with opcode (bits 29:28) 01 writes data bits 15:0 into the PHY register selected by bits 22:18.
- R3: A valid frame with opcode 10 stores the written word with bits 15:0 replaced by the selected PHY register, read back at offset 1.
- R4: Every frame write sets bit 16 of the stored frame. Opcodes 00 and 11 on a valid frame touch no PHY register.
- R5: Writing PHY register 0 with bit 15 set stores it with bit 15 cleared and bit 12 set.
- R6: Writing PHY register 0 with bit 9 set stores it with bit 9 cleared and sets bit 5 of register 1. If `link_up` is high, it also sets bit 2 of register 1 and bit 8 of register 5.
- R7: Configuration bits 9:8 ignore writes and reset to 01. All other configuration bits store what is written and reset to 0.
- R8: After reset, register 1 reads 0x4028 plus bit 2 when the link is up, register 4 reads 0x0100, register 5 bit 8 equals the link, and every other register reads 0. The frame, event and `irq` read 0.
- R9: A change of `link_up` sets register 1 bit 2 and register 5 bit 8 to the new level at the next edge. It also sets the event bit and `irq`.
- R10: Reading offset 2 returns the event in bit 0 and clears it at that edge. A link change in the same cycle keeps the event set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset |
| link_up | input | 1 | Link level seen by the modelled PHY |
| irq | output | 1 | Sticky link-change event |

## Verification
A corrupted PHY register shows up at the ports only when a read frame selects it. The bench therefore follows every command with a frame readback and ends with a sweep of all 32 registers. A stray write to the wrong index is then caught within that sweep. A wrong event or config state shows on `irq` or on the next read of offset 0 or 2, one cycle later. Random frames mix foreign addresses, bad start codes and side-effect bits in the control register with link toggles, so the interaction between the control side effects and link tracking is exercised as well.

// File: rtl/mii_cmd_pkg.sv
package mii_cmd_pkg;
  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [1:0]  ta;
    logic [15:0] data;
  } frame_t;

  localparam logic [1:0] START_OK = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ADV  = 4;
  localparam int IDX_PART = 5;

  localparam int CTRL_SOFTRST = 15;
  localparam int CTRL_ANEN    = 12;
  localparam int CTRL_RESTART = 9;
  localparam int STAT_ANDONE  = 5;
  localparam int STAT_LINK    = 2;
  localparam int ABIL_100FD   = 8;

  localparam logic [1:0] OFS_CFG   = 2'd0;
  localparam logic [1:0] OFS_FRAME = 2'd1;
  localparam logic [1:0] OFS_EVT   = 2'd2;

  localparam logic [31:0] CFG_RST_VAL = 32'h0000_0100;
  localparam logic [31:0] CFG_RO_MASK = 32'h0000_0300;

  function automatic logic [15:0] phy_rst_val(input int idx);
    if (idx == IDX_STAT)     return 16'h4028;
    else if (idx == IDX_ADV) return 16'h0100;
    else                     return 16'h0000;
  endfunction
endpackage

// File: rtl/mii_rst_sync.sv
module mii_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mii_frame_exec.sv
module mii_frame_exec
  import mii_cmd_pkg::*;
#(
  parameter int          IDX_W    = 5,
  parameter int          DATA_W   = 16,
  parameter logic [4:0]  PHY_ADDR = 5'd1
) (
  input  frame_t              frame_in,
  input  logic [DATA_W-1:0]   phy_rdata,
  output logic                phy_we,
  output logic [IDX_W-1:0]    phy_idx,
  output logic [DATA_W-1:0]   phy_wdata,
  output frame_t              frame_out
);
  logic go;

  // R1: only a proper start code addressed to the local PHY executes
  assign go        = (frame_in.st == START_OK) && (frame_in.phy == PHY_ADDR);
  assign phy_we    = go && (frame_in.op == OP_WRITE);
  assign phy_idx   = frame_in.ra[IDX_W-1:0];
  assign phy_wdata = frame_in.data[DATA_W-1:0];

  always_comb begin
    frame_out = frame_in;
    if (go && (frame_in.op == OP_READ)) frame_out.data = phy_rdata;  // R3
    frame_out.ta[0] = 1'b1;                                          // R4
  end
endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
  import mii_cmd_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  input  logic              link_up,
  output logic              link_evt
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];
  logic              link_q, primed_q;
  logic              link_chg;

  assign rdata    = regs_q[ridx];
  assign link_chg = primed_q && (link_up != link_q);
  assign link_evt = link_chg;

  always_comb begin
    logic [DATA_W-1:0] v;
    regs_d = regs_q;
    v      = wdata;
    if (we) begin
      if (widx == IDX_W'(IDX_CTRL)) begin
        if (v[CTRL_SOFTRST]) begin                 // R5
          v[CTRL_SOFTRST] = 1'b0;
          v[CTRL_ANEN]    = 1'b1;
        end
        if (v[CTRL_RESTART]) begin                 // R6
          v[CTRL_RESTART]               = 1'b0;
          regs_d[IDX_STAT][STAT_ANDONE] = 1'b1;
          if (link_up) begin
            regs_d[IDX_STAT][STAT_LINK]  = 1'b1;
            regs_d[IDX_PART][ABIL_100FD] = 1'b1;
          end
        end
      end
      regs_d[widx] = v;                            // R2
    end
    // R8/R9: first cycle after reset samples the link, later only changes
    if (!primed_q || link_chg) begin
      regs_d[IDX_STAT][STAT_LINK]  = link_up;
      regs_d[IDX_PART][ABIL_100FD] = link_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= phy_rst_val(i);
      link_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      link_q   <= link_up;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mii_cmd_pkg::*;
#(
  parameter int         NREG     = 32,
  parameter int         DATA_W   = 16,
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int         SYNC_STG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        link_up,
  output logic        irq
);
  localparam int IDX_W = $clog2(NREG);

  logic              rst_sync_n;
  logic [31:0]       cfg_q, cfg_d;
  frame_t            frame_q, frame_d;
  logic              evt_q, evt_d;
  logic              cfg_en, frame_en, evt_rd;
  logic              exec_we, link_evt;
  logic [IDX_W-1:0]  exec_idx;
  logic [DATA_W-1:0] exec_wdata, phy_rdata;

  mii_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign cfg_en   = reg_valid && reg_write  && (reg_addr == OFS_CFG);
  assign frame_en = reg_valid && reg_write  && (reg_addr == OFS_FRAME);
  assign evt_rd   = reg_valid && !reg_write && (reg_addr == OFS_EVT);

  mii_frame_exec #(.IDX_W(IDX_W), .DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)) u_exec (
    .frame_in(frame_t'(reg_wdata)), .phy_rdata(phy_rdata),
    .phy_we(exec_we), .phy_idx(exec_idx), .phy_wdata(exec_wdata),
    .frame_out(frame_d)
  );

  mii_phy_model #(.NREG(NREG), .DATA_W(DATA_W)) u_phy (
    .clk(clk), .rst_n(rst_sync_n),
    .we(frame_en && exec_we), .widx(exec_idx), .wdata(exec_wdata),
    .ridx(exec_idx), .rdata(phy_rdata),
    .link_up(link_up), .link_evt(link_evt)
  );

  // R7: transceiver-detect bits keep their value on writes
  assign cfg_d = (reg_wdata & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
  // R10: a new event wins over the clear of a read
  assign evt_d = link_evt | (evt_q & ~evt_rd);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q   <= CFG_RST_VAL;
      frame_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (cfg_en)   cfg_q   <= cfg_d;
      if (frame_en) frame_q <= frame_d;
      evt_q <= evt_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CFG:   reg_rdata = cfg_q;
      OFS_FRAME: reg_rdata = frame_q;
      OFS_EVT:   reg_rdata = {31'b0, evt_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = evt_q;  // R9
endmodule

// File: rtl/mii_mgmt_engine_chk.sv
module mii_mgmt_engine_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq,
  input logic [31:0] cfg_q,
  input logic [31:0] frame_q
);
  logic wr_frame, wr_cfg, rd_evt;
  assign wr_frame = reg_valid && reg_write  && (reg_addr == 2'd1);
  assign wr_cfg   = reg_valid && reg_write  && (reg_addr == 2'd0);
  assign rd_evt   = reg_valid && !reg_write && (reg_addr == 2'd2);

  a_r4_done_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_frame |=> frame_q[16]);

  a_r1_foreign_frame: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_frame && (reg_wdata[31:30] != 2'b01 || reg_wdata[27:23] != 5'd1))
      |=> frame_q == ($past(reg_wdata) | 32'h0001_0000));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_frame |=> frame_q[31:17] == $past(reg_wdata[31:17]));

  a_r7_cfg_ro: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_cfg |=> cfg_q[9:8] == $past(cfg_q[9:8]));

  a_r7_cfg_rw: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_cfg |=> cfg_q[7:0] == $past(reg_wdata[7:0]));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !rd_evt) |=> irq);

  a_r10_evt_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_evt |-> reg_rdata == {31'b0, irq});
endmodule

bind mii_mgmt_engine mii_mgmt_engine_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq), .cfg_q(cfg_q), .frame_q(frame_q)
);

// File: tb/tb_mii_mgmt_engine.sv
`timescale 1ns/1ps
module tb_mii_mgmt_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_up = 1'b1;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_phy [32];
  logic        m_evt;
  logic [31:0] m_cfg;

  always #4 clk = ~clk;

  mii_mgmt_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_up(link_up), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  function automatic void mdl_phy_wr(input int idx, input logic [15:0] d, input logic lk);
    logic [15:0] v = d;
    if (idx == 0) begin
      if (v[15]) begin v[15] = 1'b0; v[12] = 1'b1; end
      if (v[9]) begin
        v[9] = 1'b0; m_phy[1][5] = 1'b1;
        if (lk) begin m_phy[1][2] = 1'b1; m_phy[5][8] = 1'b1; end
      end
    end
    m_phy[idx] = v;
  endfunction

  function automatic logic [31:0] mdl_frame(input logic [31:0] w, input logic lk);
    logic [31:0] r = w;
    if (w[31:30] == 2'b01 && w[27:23] == 5'd1) begin
      if (w[29:28] == 2'b01) mdl_phy_wr(int'(w[22:18]), w[15:0], lk);
      else if (w[29:28] == 2'b10) r[15:0] = m_phy[w[22:18]];
    end
    r[16] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] ph, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, ph, ra, 2'b00, d};
  endfunction

  task automatic do_frame(input logic [31:0] w, input string tag);
    logic [31:0] exp, got;
    exp = mdl_frame(w, link_up);
    bus_wr(2'd1, w);
    bus_rd(2'd1, got);
    chk(tag, got, exp);
  endtask

  task automatic phy_chk(input int idx, input string tag);
    do_frame(mk(2'b01, 2'b10, 5'd1, idx[4:0], 16'hA5A5), tag);
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    if (v !== link_up) begin
      link_up = v; m_phy[1][2] = v; m_phy[5][8] = v; m_evt = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic evt_chk(input string tag);
    logic [31:0] got;
    bus_rd(2'd2, got);
    chk(tag, got, {31'b0, m_evt});
    m_evt = 1'b0;
    chk(tag, {31'b0, irq}, 32'd0);
  endtask

  task automatic cfg_wr_chk(input logic [31:0] w, input string tag);
    logic [31:0] got;
    m_cfg = (w & ~32'h300) | (m_cfg & 32'h300);
    bus_wr(2'd0, w);
    bus_rd(2'd0, got);
    chk(tag, got, m_cfg);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] got, w;
    int sel;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_phy[i] = 16'h0;
    m_phy[1] = 16'h402C; m_phy[4] = 16'h0100; m_phy[5] = 16'h0100;
    m_evt = 1'b0; m_cfg = 32'h100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7/R8 reset state
    bus_rd(2'd0, got); chk("R7 cfg reset", got, 32'h100);
    bus_rd(2'd1, got); chk("R8 frame reset", got, 32'h0);
    bus_rd(2'd2, got); chk("R8 evt reset", got, 32'h0);
    chk("R8 irq reset", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 32; i++) phy_chk(i, "R8 phy reset");

    // R7 read-only detect bits
    cfg_wr_chk(32'hFFFF_FEFF, "R7 cfg ro");
    cfg_wr_chk(32'h0000_0200, "R7 cfg ro2");

    // R1 foreign start and foreign PHY
    do_frame(mk(2'b00, 2'b01, 5'd1, 5'd4, 16'hBEEF), "R1 bad start");
    do_frame(mk(2'b01, 2'b01, 5'd0, 5'd4, 16'hBEEF), "R1 bad phy");
    phy_chk(4, "R1 untouched");

    // R2 write, R3 read
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd7, 16'h1234), "R2 write");
    phy_chk(7, "R3 read");
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd31, 16'hFFFF), "R2 write top");
    phy_chk(31, "R3 read top");

    // R4 opcodes 00 / 11
    do_frame(mk(2'b01, 2'b00, 5'd1, 5'd7, 16'h0000), "R4 op00");
    do_frame(mk(2'b01, 2'b11, 5'd1, 5'd7, 16'h0000), "R4 op11");
    phy_chk(7, "R4 untouched");

    // R5 soft reset
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h8000), "R5 ctrl wr");
    phy_chk(0, "R5 ctrl");

    // R9 link down event
    set_link(1'b0);
    chk("R9 irq", {31'b0, irq}, 32'd1);
    phy_chk(1, "R9 stat down"); phy_chk(5, "R9 part down");
    evt_chk("R10 evt clear");

    // R6 restart with link down then up
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000), "R6 stat clr");
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h0200), "R6 restart down");
    phy_chk(1, "R6 stat down"); phy_chk(5, "R6 part down"); phy_chk(0, "R6 ctrl");
    set_link(1'b1);
    evt_chk("R10 evt up");
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd1, 16'h0000), "R6 stat clr2");
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd5, 16'h0000), "R6 part clr");
    do_frame(mk(2'b01, 2'b01, 5'd1, 5'd0, 16'h8200), "R6 restart up");
    phy_chk(1, "R6 stat up"); phy_chk(5, "R6 part up"); phy_chk(0, "R6 ctrl both");

    // R10 link change in the read cycle keeps the event
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 2'd2; link_up = 1'b0;
    #1 chk("R10 read old", reg_rdata, 32'd0);
    @(negedge clk);
    reg_valid = 1'b0;
    m_phy[1][2] = 1'b0; m_phy[5][8] = 1'b0; m_evt = 1'b1;
    chk("R10 set wins", {31'b0, irq}, 32'd1);
    evt_chk("R10 clear after");

    // random mix
    for (int it = 0; it < 400; it++) begin
      sel = int'($urandom % 10);
      if (sel < 6) begin
        w = $urandom;
        if ($urandom % 8 != 0) w[31:30] = 2'b01;
        if ($urandom % 8 != 0) w[27:23] = 5'd1;
        if ($urandom % 2 == 0) begin
          case ($urandom % 4)
            0: w[22:18] = 5'd0; 1: w[22:18] = 5'd1;
            2: w[22:18] = 5'd4; default: w[22:18] = 5'd5;
          endcase
        end
        do_frame(w, "R2 R3 random frame");
      end else if (sel < 8) begin
        set_link(1'($urandom));
        chk("R9 random irq", {31'b0, irq}, {31'b0, m_evt});
      end else if (sel == 8) begin
        evt_chk("R10 random evt");
      end else begin
        cfg_wr_chk($urandom, "R7 random cfg");
      end
    end

    for (int i = 0; i < 32; i++) phy_chk(i, "R2 final sweep");
    summary();
  end
endmodule